// File: doc/BRIEF.md
# Boost Pulse Mode Controller

This block is the digital control side of an inductor boost regulator. It decides when the power switch is closed and for how long. The analog power stage, the output comparator and both oscillators sit outside it. It runs on a fast system clock. It receives a slow 32 kHz reference clock and an "output below target" comparator flag, and both of these are asynchronous to the system clock.

In active mode the converter is fully regulating. The switching events then come either from a divider on the fast clock or from the rising edges of the slow clock. In standby mode most of the logic is idle. The exception is automatic pulse mode: when it is enabled, every rising edge and every falling edge of the slow clock is an opportunity for one fixed-width inductor pulse. A pulse is issued only if the comparator says the output is low. While the chip is in hibernate, the block is held in standby. Mode and frequency requests are applied only between pulses. The status outputs report the applied mode, the applied frequency and whether the most recent switching opportunity produced a pulse.

Top module: `boost_pulse_ctrl`

## Requirements
- R1: In active mode with the fast frequency selected (freq_o = 0), a switching opportunity occurs once every FAST_DIV system clock cycles. With the slow frequency selected (freq_o = 1), an opportunity occurs only on rising edges of the slow clock.
- R2: mode_o reports the applied mode, with 0 for active and 1 for standby. freq_o reports the applied frequency, with 0 for fast and 1 for slow. Both follow mode_req_i and freq_req_i.
- R3: In standby with auto_en_i = 1, every rising edge and every falling edge of the slow clock is a switching opportunity, whatever freq_req_i selects.
- R4: An opportunity starts a pulse only when the synchronized comparator flag is 1. With the flag at 0, no pulse is issued.
- R5: While hib_i = 1, the applied mode is standby (mode_o = 1), whatever mode_req_i requests.
- R6: A pulse holds sw_drive_o high for exactly pulse_len_i system cycles, and a value of 0 is treated as 1. An opportunity that arrives while a pulse is running is dropped and does not start or extend a pulse.
- R7: mode_o and freq_o change only at a clock edge at which no pulse is running. A request made during a pulse is applied after the pulse ends.
- R8: The comparator flag and the slow clock each pass through a two-stage synchronizer of equal depth. A comparator rise that arrives in the same cycle as a slow clock edge gates that edge. A rise one cycle later does not gate it.
- R9: pulse_hit_o is updated at every switching opportunity. It becomes 1 if that opportunity started a pulse and 0 otherwise.
- R10: In standby with auto_en_i = 0, no pulse is issued.
- R11: After a synchronous reset, sw_drive_o = 0, mode_o = 1, freq_o = 1 and pulse_hit_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk_i | input | 1 | 32 kHz reference clock, asynchronous |
| cmp_low_i | input | 1 | Comparator flag, 1 when the output is below target, asynchronous |
| mode_req_i | input | 1 | Requested mode: 0 active, 1 standby |
| freq_req_i | input | 1 | Requested frequency: 0 fast divider, 1 slow clock |
| auto_en_i | input | 1 | Enables automatic pulse mode in standby |
| hib_i | input | 1 | Chip hibernate state, forces standby |
| pulse_len_i | input | LEN_W | Pulse width in system cycles (0 acts as 1) |
| sw_drive_o | output | 1 | Inductor switch drive |
| mode_o | output | 1 | Applied mode |
| freq_o | output | 1 | Applied frequency |
| pulse_hit_o | output | 1 | 1 if the last opportunity produced a pulse |

## Verification
The comparator-gating assertion assumes that cmp_low_i is a level that holds for several system cycles and starts at a known value, so that its value three cycles before a pulse begins is meaningful. The bench drives it from time zero and changes it only on falling clock edges. The slow clock is assumed to have half periods much longer than the synchronizer depth and the longest pulse. The bench uses 64-cycle half periods and pulses of at most 60 cycles, so each edge is seen as exactly one opportunity. Mode and pulse-length changes are followed by a settling interval longer than any pulse before counting starts.

// File: rtl/boost_pkg.sv
package boost_pkg;
  typedef enum logic {
    MODE_ACTIVE  = 1'b0,
    MODE_STANDBY = 1'b1
  } mode_e;

  typedef enum logic {
    FREQ_FAST = 1'b0,
    FREQ_SLOW = 1'b1
  } freq_e;
endpackage

// File: rtl/boost_sync.sv
module boost_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/boost_tick_gen.sv
module boost_tick_gen
  import boost_pkg::*;
#(
  parameter int FAST_DIV = 20
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  slow_s_i,
  input  mode_e mode_i,
  input  freq_e freq_i,
  input  logic  auto_en_i,
  output logic  tick_o
);
  localparam int DW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(FAST_DIV - 1);

  logic [DW-1:0] div_q;
  logic          slow_prev_q;
  logic          rise, fall, div_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q       <= '0;
      slow_prev_q <= 1'b0;
    end else begin
      slow_prev_q <= slow_s_i;
      div_q       <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end
  end

  assign rise     = slow_s_i & ~slow_prev_q;
  assign fall     = ~slow_s_i & slow_prev_q;
  assign div_wrap = (div_q == DIV_LAST);

  always_comb begin
    if (mode_i == MODE_ACTIVE)
      tick_o = (freq_i == FREQ_FAST) ? div_wrap : rise;
    else
      tick_o = auto_en_i & (rise | fall);
  end
endmodule

// File: rtl/boost_pulse_gen.sv
module boost_pulse_gen #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             cmp_s_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sw_o,
  output logic             busy_o,
  output logic             hit_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] eff_len;
  logic             start;

  assign busy_o  = (cnt_q != '0);
  assign eff_len = (len_i == '0) ? LEN_W'(1) : len_i;
  assign start   = tick_i & cmp_s_i & ~busy_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sw_o  <= 1'b0;
      hit_o <= 1'b0;
    end else begin
      if (start) begin
        cnt_q <= eff_len;
        sw_o  <= 1'b1;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
        sw_o  <= (cnt_q > LEN_W'(1));
      end
      if (tick_i) hit_o <= start;
    end
  end

  // R9: a pulse that begins is reported as a hit at the same edge
  p_hit_on_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_o) |-> hit_o);

  // R6: while more than one cycle of the pulse remains, the drive stays high
  p_width_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q > LEN_W'(1)) |=> sw_o);
endmodule

// File: rtl/boost_pulse_ctrl.sv
module boost_pulse_ctrl
  import boost_pkg::*;
#(
  parameter int FAST_DIV = 20,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_clk_i,
  input  logic             cmp_low_i,
  input  logic             mode_req_i,
  input  logic             freq_req_i,
  input  logic             auto_en_i,
  input  logic             hib_i,
  input  logic [LEN_W-1:0] pulse_len_i,
  output logic             sw_drive_o,
  output logic             mode_o,
  output logic             freq_o,
  output logic             pulse_hit_o
);
  mode_e       mode_q;
  freq_e       freq_q;
  logic [1:0]  sync_q;
  logic        tick, busy;

  boost_sync #(.W(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cmp_low_i, slow_clk_i}),
    .q_o (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STANDBY;
      freq_q <= FREQ_SLOW;
    end else if (!busy) begin
      mode_q <= (hib_i || mode_req_i) ? MODE_STANDBY : MODE_ACTIVE;
      freq_q <= freq_req_i ? FREQ_SLOW : FREQ_FAST;
    end
  end

  boost_tick_gen #(.FAST_DIV(FAST_DIV)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .slow_s_i  (sync_q[0]),
    .mode_i    (mode_q),
    .freq_i    (freq_q),
    .auto_en_i (auto_en_i),
    .tick_o    (tick)
  );

  boost_pulse_gen #(.LEN_W(LEN_W)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .cmp_s_i (sync_q[1]),
    .len_i   (pulse_len_i),
    .sw_o    (sw_drive_o),
    .busy_o  (busy),
    .hit_o   (pulse_hit_o)
  );

  assign mode_o = mode_q;
  assign freq_o = freq_q;

  // R5: hibernate seen while idle leaves the block in standby
  p_hib_standby_r5: assert property (@(posedge clk) disable iff (rst)
    (hib_i && !sw_drive_o) |=> mode_o);

  // R4 and R8: a pulse begins only if the comparator was high three edges earlier
  p_cmp_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_drive_o) |-> $past(cmp_low_i, 3));

  // R7: applied mode and frequency are frozen during a pulse
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    sw_drive_o |=> ($stable(mode_o) && $stable(freq_o)));

  // R10: standby without automatic pulse mode never starts a pulse
  p_standby_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (mode_o && !auto_en_i && !sw_drive_o) |=> !sw_drive_o);
endmodule

// File: tb/tb_boost_pulse_ctrl.sv
module tb_boost_pulse_ctrl;
  localparam int FAST_DIV = 32;
  localparam int LEN_W    = 8;
  localparam int HALF     = 64;
  localparam int NV       = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_clk = 1'b0;
  logic cmp = 1'b0, mode_req = 1'b1, freq_req = 1'b1, auto_en = 1'b0, hib = 1'b0;
  logic [LEN_W-1:0] plen = 8'd5;
  logic sw, mode_o, freq_o, hit;

  int checks = 0, errors = 0;
  int rise_cnt = 0, run = 0, wbad = 0, wseen = 0, exp_w = 1;
  int slow_div = 0;
  logic slow_run = 1'b1;
  logic sw_prev = 1'b0;

  always #4 clk = ~clk;

  boost_pulse_ctrl #(.FAST_DIV(FAST_DIV), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst), .slow_clk_i(slow_clk), .cmp_low_i(cmp),
    .mode_req_i(mode_req), .freq_req_i(freq_req), .auto_en_i(auto_en),
    .hib_i(hib), .pulse_len_i(plen), .sw_drive_o(sw), .mode_o(mode_o),
    .freq_o(freq_o), .pulse_hit_o(hit)
  );

  // slow reference clock and pulse monitor, both on the falling edge
  always @(negedge clk) begin
    if (slow_run) begin
      if (slow_div == HALF - 1) begin
        slow_div = 0;
        slow_clk = ~slow_clk;
      end else slow_div = slow_div + 1;
    end
    if (sw && !sw_prev) rise_cnt = rise_cnt + 1;
    if (sw) run = run + 1;
    else if (run != 0) begin
      wseen = wseen + 1;
      if (run != exp_w) wbad = wbad + 1;
      run = 0;
    end
    sw_prev = sw;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {mode, freq, auto, hib, cmp, len[7:0], pulses[3:0], chk_hit, hit}
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd5,  4'd8, 1'b1, 1'b1}, // R1 fast divider
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5,  4'd2, 1'b1, 1'b1}, // R1 slow rising only
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd5,  4'd4, 1'b1, 1'b1}, // R3 freq ignored
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'd7,  4'd4, 1'b1, 1'b1}, // R3 both edges
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'd5,  4'd0, 1'b0, 1'b0}, // R10 no auto
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5,  4'd0, 1'b1, 1'b0}, // R4 comparator low
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5,  4'd0, 1'b1, 1'b0}, // R4 standby low
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd5,  4'd4, 1'b1, 1'b1}, // R5 hibernate
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd40, 4'd4, 1'b0, 1'b0}, // R6 drop while busy
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0,  4'd8, 1'b1, 1'b1}  // R6 zero length
  };

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cycles(5);
    // R11 reset state
    check("R11 sw", int'(sw), 0);
    check("R11 mode", int'(mode_o), 1);
    check("R11 freq", int'(freq_o), 1);
    check("R11 hit", int'(hit), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      int r0, pulses, len;
      e = VEC[v];
      mode_req = e[18]; freq_req = e[17]; auto_en = e[16]; hib = e[15];
      cmp = e[14]; plen = e[13:6];
      len = (e[13:6] == 0) ? 1 : int'(e[13:6]);
      exp_w = len;
      cycles(150);
      wbad = 0; wseen = 0;
      r0 = rise_cnt;
      cycles(4 * HALF);
      pulses = rise_cnt - r0;
      cycles(HALF);
      check($sformatf("R1/R3/R4/R6/R10 pulses v%0d", v), pulses, int'(e[5:2]));
      check($sformatf("R6 width v%0d", v), wbad, 0);
      if (e[5:2] != 0) check($sformatf("R6 widths seen v%0d", v), int'(wseen > 0), 1);
      check($sformatf("R2/R5 mode v%0d", v), int'(mode_o), int'(e[18] | e[15]));
      check($sformatf("R2 freq v%0d", v), int'(freq_o), int'(e[17]));
      if (e[1]) check($sformatf("R9 hit v%0d", v), int'(hit), int'(e[0]));
    end

    // R7: a mode request during a pulse waits for the pulse to end
    mode_req = 1'b1; freq_req = 1'b1; auto_en = 1'b1; hib = 1'b0;
    cmp = 1'b1; plen = 8'd60; exp_w = 60;
    cycles(150);
    begin
      int r0;
      r0 = rise_cnt;
      while (rise_cnt == r0) @(negedge clk);
    end
    cycles(3);
    mode_req = 1'b0;
    cycles(3);
    check("R7 mode held during pulse", int'(mode_o), 1);
    while (sw) @(negedge clk);
    cycles(2);
    check("R7 mode applied after pulse", int'(mode_o), 0);

    // R8: comparator rise aligned with a slow edge gates that edge
    mode_req = 1'b1; cmp = 1'b0; plen = 8'd5; exp_w = 5;
    cycles(150);
    begin
      int r0;
      @(slow_clk);
      cmp = 1'b1;
      r0 = rise_cnt;
      cycles(20);
      check("R8 aligned rise gates edge", rise_cnt - r0, 1);
      cmp = 1'b0;
      cycles(150);
      @(slow_clk);
      @(negedge clk);
      cmp = 1'b1;
      r0 = rise_cnt;
      cycles(20);
      check("R8 late rise misses edge", rise_cnt - r0, 0);
      check("R9 missed edge clears hit", int'(hit), 0);
    end

    // R11 reset again mid-run
    cmp = 1'b1;
    rst = 1'b1;
    cycles(3);
    check("R11 sw after reset", int'(sw), 0);
    check("R11 hit after reset", int'(hit), 0);
    check("R11 mode after reset", int'(mode_o), 1);
    rst = 1'b0;
    cycles(5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule